// File: doc/BRIEF.md
# Indirect Interrupt Redirection Table

The block routes a set of hardwired interrupt input lines to interrupt delivery messages. Each input has its own routing entry, and each entry is 64 bits wide in the software view. The entry holds the vector to deliver, a flag that asks for lowest-priority delivery, the sense of the input (active-high or active-low), the trigger style (edge or level), a mask bit and an 8-bit destination. Software never addresses an entry directly. It writes a select register that picks one 32-bit half of one entry, then reads or writes that half through a 32-bit data window.

When an unmasked entry sees its input become active (edge style) or finds it active (level style), the block emits a single-cycle message carrying the vector, the destination and the delivery flag. A level entry then waits in a remote-pending state until an end-of-interrupt carrying the same vector arrives. If several entries request in the same cycle, the lowest entry number goes first and the others follow one per cycle. Software updates an entry safely in three writes: it masks the low half, writes the high half, then writes the final low half.

Top module: `irq_route_table`

## Requirements
- R1: After reset every entry is masked, so each low half reads 0x00010000 and each high half reads 0, and no message is emitted.
- R2: A select value of 0x10+2e reaches the low half of entry e and 0x11+2e reaches its high half, for e from 0 to 23. Any other select value reads 0, and writes through it change no entry.
- R3: Low-half layout: bits [7:0] vector, bit 8 lowest-priority flag, bit 13 polarity (1 = active-low), bit 14 remote pending (read-only), bit 15 trigger (1 = level), bit 16 mask (1 = masked). High-half layout: bits [31:24] destination. Every other bit reads 0.
- R4: On an unmasked edge entry, a change of the input from inactive to active gives exactly one message. msg_valid is high in the cycle after the second rising clock edge that follows the input change, and the message carries the entry's vector, destination and lowest-priority flag.
- R5: Input edges that arrive while an entry is masked are discarded, so unmasking the entry later sends nothing. A masked level entry sends nothing while its input is active.
- R6: On an active-low entry, a low input is active and a high input is inactive.
- R7: A level entry with an active input and remote pending clear sends one message and sets remote pending. It sends nothing more until an end-of-interrupt with an equal vector clears that bit. An end-of-interrupt with any other vector has no effect. After the clear, the entry sends again if its input is still active.
- R8: When several entries request in the same cycle, the lowest entry number is delivered first. The others are held and delivered in later cycles, one per cycle, in ascending order.
- R9: An unmasked entry whose vector is below 0x20 never sends a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_we | input | 1 | Load the half-entry select register |
| sel_wdata | input | 8 | New select value |
| win_we | input | 1 | Write the selected half through the data window |
| win_wdata | input | 32 | Data window write value |
| win_rdata | output | 32 | Data window read value for the current select |
| irq_in | input | 24 | Hardwired interrupt input lines, one per entry |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_valid | output | 1 | Delivery message valid for one cycle |
| msg_vector | output | 8 | Vector of the message |
| msg_dest | output | 8 | Destination of the message |
| msg_lowpri | output | 1 | Message requests lowest-priority delivery |

## Verification
The bench programs every entry with its own vector and destination, reads back both halves, and then checks the delivery latency and the single-pulse behaviour. A design that rearms on a held input would emit a second message. A design that mis-maps the select register would read or deliver the wrong entry. Edges on a masked entry are checked after the entry is unmasked, which catches a design that keeps them latched. The level and end-of-interrupt test uses an active-low entry and a non-matching vector, which exposes an inverted polarity, a remote-pending bit that clears on any end-of-interrupt, and a level entry that never rearms. A simultaneous two-input burst catches a wrong priority order or a lost second request, and a vector below 0x20 must stay silent.

// File: rtl/irq_route_table.sv
module irq_route_table #(
  parameter int NUM_ENT  = 24,
  parameter int IDX_BASE = 16,
  parameter int MIN_VEC  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic [7:0]         sel_wdata,
  input  logic               win_we,
  input  logic [31:0]        win_wdata,
  output logic [31:0]        win_rdata,
  input  logic [NUM_ENT-1:0] irq_in,
  input  logic               eoi_valid,
  input  logic [7:0]         eoi_vector,
  output logic               msg_valid,
  output logic [7:0]         msg_vector,
  output logic [7:0]         msg_dest,
  output logic               msg_lowpri
);

  localparam int EW = $clog2(NUM_ENT);
  localparam logic [8:0] SEL_LO = 9'(IDX_BASE);
  localparam logic [8:0] SEL_HI = 9'(IDX_BASE + 2 * NUM_ENT);

  logic [7:0] sel_q;
  logic [7:0] vec [NUM_ENT];
  logic [7:0] dst [NUM_ENT];
  logic       lp  [NUM_ENT];
  logic       pol [NUM_ENT];
  logic       trig[NUM_ENT];
  logic       msk [NUM_ENT];
  logic       rirr[NUM_ENT];
  logic       pend[NUM_ENT];
  logic [NUM_ENT-1:0] lvl_q, lvl_d, req, grant;
  logic [EW-1:0] win;
  logic hit;

  wire [7:0] off    = sel_q - SEL_LO[7:0];
  wire [7:0] ent    = off >> 1;
  wire       half   = off[0];
  wire       in_rng = ({1'b0, sel_q} >= SEL_LO) && ({1'b0, sel_q} < SEL_HI);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= '0;
    else if (sel_we) sel_q <= sel_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q <= '0;
      lvl_d <= '0;
    end else begin
      lvl_q <= irq_in;
      lvl_d <= lvl_q;
    end

  always_comb begin
    win_rdata = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (in_rng && ent == 8'(i))
        win_rdata = half ? {dst[i], 24'd0}
                         : {15'd0, msk[i], trig[i], rirr[i], pol[i], 4'd0, lp[i], vec[i]};
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    wire wr_lo = win_we && in_rng && ent == 8'(g) && !half;
    wire wr_hi = win_we && in_rng && ent == 8'(g) && half;
    wire ok    = !msk[g] && (vec[g] >= 8'(MIN_VEC));
    wire act   = lvl_q[g] ^ pol[g];
    wire act_d = lvl_d[g] ^ pol[g];
    wire rise  = act && !act_d;

    assign req[g] = ok && (trig[g] ? (act && !rirr[g]) : (pend[g] || rise));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        vec[g]  <= '0;
        dst[g]  <= '0;
        lp[g]   <= 1'b0;
        pol[g]  <= 1'b0;
        trig[g] <= 1'b0;
        msk[g]  <= 1'b1;
        rirr[g] <= 1'b0;
        pend[g] <= 1'b0;
      end else begin
        pend[g] <= ok && !trig[g] && !grant[g] && (pend[g] || rise);
        if (grant[g] && trig[g])
          rirr[g] <= 1'b1;
        else if (eoi_valid && rirr[g] && eoi_vector == vec[g])
          rirr[g] <= 1'b0;
        if (wr_lo) begin
          vec[g]  <= win_wdata[7:0];
          lp[g]   <= win_wdata[8];
          pol[g]  <= win_wdata[13];
          trig[g] <= win_wdata[15];
          msk[g]  <= win_wdata[16];
          if (!win_wdata[15]) rirr[g] <= 1'b0;
        end
        if (wr_hi) dst[g] <= win_wdata[31:24];
      end

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      rirr[g] |-> !grant[g]); // R7
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && rirr[g] && eoi_vector == vec[g]) |=> !rirr[g]); // R7
    AST_MASK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      msk[g] |=> !pend[g]); // R5
  end

  always_comb begin
    win = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (req[i]) win = EW'(i);
    hit   = |req;
    grant = '0;
    grant[win] = hit;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_dest   <= '0;
      msg_lowpri <= 1'b0;
    end else begin
      msg_valid  <= hit;
      msg_vector <= vec[win];
      msg_dest   <= dst[win];
      msg_lowpri <= lp[win];
    end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8
  AST_REQ_SENDS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> msg_valid); // R4
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_vector >= 8'(MIN_VEC)); // R9

endmodule

// File: tb/test_irq_route_table.sv
module test_irq_route_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0;
  logic [7:0]  sel_wdata = '0;
  logic        win_we = 1'b0;
  logic [31:0] win_wdata = '0;
  logic [31:0] win_rdata;
  logic [23:0] irq_in = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid;
  logic [7:0]  msg_vector, msg_dest;
  logic        msg_lowpri;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_route_table i_irq_route_table (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .win_we(win_we), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .irq_in(irq_in), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .msg_lowpri(msg_lowpri));

  task automatic chk(string r, logic [31:0] a, logic [31:0] e);
    n_run++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sel(logic [7:0] v);
    sel_we = 1'b1; sel_wdata = v; step(); sel_we = 1'b0;
  endtask

  task automatic wr(logic [7:0] idx, logic [31:0] d);
    sel(idx); win_we = 1'b1; win_wdata = d; step(); win_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] idx, output logic [31:0] d);
    sel(idx); d = win_rdata;
  endtask

  function automatic logic [31:0] lo_word(logic [7:0] v, logic l, logic p, logic t, logic m);
    return {15'd0, m, t, 1'b0, p, 4'd0, l, v};
  endfunction

  task automatic prog(int e, logic [7:0] v, logic [7:0] d, logic l, logic p, logic t, logic m);
    wr(8'(16 + 2 * e), 32'h0001_0000);
    wr(8'(17 + 2 * e), {d, 24'd0});
    wr(8'(16 + 2 * e), lo_word(v, l, p, t, m));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    step(); step();
    rst_n = 1'b1;
    step();

    chk("R1 msg_valid idle", 32'(msg_valid), 0);
    rd(8'h10, r); chk("R1 entry0 low", r, 32'h0001_0000);
    rd(8'h3E, r); chk("R1 entry23 low", r, 32'h0001_0000);
    rd(8'h3F, r); chk("R1 entry23 high", r, 0);
    chk("R1 msg_valid after reads", 32'(msg_valid), 0);

    for (int i = 0; i < 24; i++) begin
      logic [7:0] v, d;
      logic l;
      v = 8'(32 + i * 9);
      d = 8'(i * 11);
      l = i[0];
      prog(i, v, d, l, 1'b0, 1'b0, 1'b0);
      rd(8'(16 + 2 * i), r); chk("R3 low readback", r, lo_word(v, l, 1'b0, 1'b0, 1'b0));
      rd(8'(17 + 2 * i), r); chk("R2 high readback", r, {d, 24'd0});
      irq_in[i] = 1'b1;
      step(); chk("R4 not yet", 32'(msg_valid), 0);
      step();
      chk("R4 valid", 32'(msg_valid), 1);
      chk("R4 vector", 32'(msg_vector), 32'(v));
      chk("R4 dest", 32'(msg_dest), 32'(d));
      chk("R4 lowpri", 32'(msg_lowpri), 32'(l));
      irq_in[i] = 1'b0;
      step(); chk("R4 single message", 32'(msg_valid), 0);
      wr(8'(16 + 2 * i), 32'h0001_0000);
    end

    rd(8'h0F, r); chk("R2 below range", r, 0);
    rd(8'h40, r); chk("R2 above range", r, 0);
    wr(8'h0F, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h10, r); chk("R2 ignored write low", r, 32'h0001_0000);
    rd(8'h3F, r); chk("R2 ignored write high", r, {8'(23 * 11), 24'd0});

    wr(8'h1C, lo_word(8'h70, 1'b0, 1'b0, 1'b0, 1'b1));
    irq_in[6] = 1'b1;
    step(); step(); chk("R5 masked edge", 32'(msg_valid), 0);
    irq_in[6] = 1'b0;
    step();
    wr(8'h1C, lo_word(8'h70, 1'b0, 1'b0, 1'b0, 1'b0));
    step(); chk("R5 no late delivery", 32'(msg_valid), 0);
    step(); chk("R5 no late delivery 2", 32'(msg_valid), 0);
    prog(7, 8'h78, 8'h07, 1'b0, 1'b0, 1'b1, 1'b1);
    irq_in[7] = 1'b1;
    step(); step(); step(); chk("R5 masked level", 32'(msg_valid), 0);
    irq_in[7] = 1'b0;
    step();

    irq_in[5] = 1'b1;
    prog(5, 8'h60, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0);
    step(); step(); chk("R6 high inactive", 32'(msg_valid), 0);
    irq_in[5] = 1'b0;
    step(); chk("R6 not yet", 32'(msg_valid), 0);
    step();
    chk("R6 low active", 32'(msg_valid), 1);
    chk("R7 vector", 32'(msg_vector), 32'h60);
    chk("R7 dest", 32'(msg_dest), 32'h5A);
    step(); chk("R7 held", 32'(msg_valid), 0);
    step(); chk("R7 held 2", 32'(msg_valid), 0);
    rd(8'h1A, r); chk("R7 remote pending set", r, lo_word(8'h60, 1'b0, 1'b1, 1'b1, 1'b0) | 32'h4000);
    eoi_valid = 1'b1; eoi_vector = 8'h61;
    step(); eoi_valid = 1'b0;
    step(); chk("R7 other eoi ignored", 32'(msg_valid), 0);
    rd(8'h1A, r); chk("R7 pending kept", r[14], 1);
    eoi_valid = 1'b1; eoi_vector = 8'h60;
    step(); eoi_valid = 1'b0;
    chk("R7 cleared edge", 32'(msg_valid), 0);
    step(); chk("R7 resend", 32'(msg_valid), 1);
    irq_in[5] = 1'b1;
    eoi_valid = 1'b1;
    step(); eoi_valid = 1'b0;
    step(); step(); chk("R7 inactive after eoi", 32'(msg_valid), 0);
    rd(8'h1A, r); chk("R7 pending clear", r[14], 0);
    wr(8'h1A, 32'h0001_0000);

    prog(3, 8'h33, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0);
    prog(9, 8'h99, 8'h09, 1'b0, 1'b0, 1'b0, 1'b0);
    irq_in[3] = 1'b1; irq_in[9] = 1'b1;
    step(); step();
    chk("R8 first valid", 32'(msg_valid), 1);
    chk("R8 first lowest", 32'(msg_vector), 32'h33);
    step();
    chk("R8 second valid", 32'(msg_valid), 1);
    chk("R8 second vector", 32'(msg_vector), 32'h99);
    chk("R8 second dest", 32'(msg_dest), 32'h09);
    irq_in[3] = 1'b0; irq_in[9] = 1'b0;
    step(); chk("R8 drained", 32'(msg_valid), 0);

    prog(4, 8'h1F, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0);
    irq_in[4] = 1'b1;
    step(); step(); chk("R9 low vector silent", 32'(msg_valid), 0);
    step(); chk("R9 low vector silent 2", 32'(msg_valid), 0);
    irq_in[4] = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule